// File: doc/BRIEF.md
# Latching Interrupt Priority Arbiter

This block sits between a set of hardware interrupt request lines, a software-interrupt request from the instruction decoder, and the CPU core's exception sequencer. It reports whether any request is worth taking. When the CPU strobes the start of interrupt processing, the block runs one arbitration and records the winner as a small fixed vector code. The CPU uses that code to pick the vector to fetch.

The recorded choice is held steady until the CPU acknowledges that the interrupt was serviced, or until the interrupt mask bit goes from set to clear. While the choice is held, no other request can replace it, even one with a higher priority. Hardware requests are blocked while the mask bit is set. The software interrupt is never blocked and beats every hardware line. Among hardware lines, the lowest index wins.

Top module: `irq_latch_arbiter`

## Requirements
- R1: In the cycle after a synchronous reset, `vec_valid` is 0 and `vec_code` is 0.
- R2: `irq_pend` is combinational. It equals `swi_req` OR (any bit of `irq_req` set AND `i_mask` low).
- R3: When nothing is held and `start_strb` is high with `irq_pend` high, the next cycle shows `vec_valid`=1. If `swi_req` was high, `vec_code` is 1, whatever the hardware lines are.
- R4: If no software request is present, hardware line i wins only when no line with a lower index is requesting. Its code is i+2.
- R5: A strobe while `irq_pend` is low latches nothing. This includes hardware requests that are blocked by `i_mask`=1: `vec_valid` stays 0 and `vec_code` stays 0.
- R6: While a selection is held and no release occurs, `vec_code` and `vec_valid` do not change, whatever the requests and strobes.
- R7: `svc_ack` high while a selection is held makes `vec_valid` and `vec_code` both 0 in the next cycle.
- R8: When `i_mask` was 1 in the previous cycle and is 0 now, a held selection is released in the next cycle (`vec_valid`=0, `vec_code`=0). After reset the previous mask value counts as 1.
- R9: If a strobe arrives in the same cycle as a release of a held selection, the release wins and nothing new is latched that cycle. If `svc_ack` arrives while nothing is held, it has no effect, so a strobe in that same cycle still latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | NUM_SRC | Hardware request lines; index 0 has the highest priority |
| swi_req | input | 1 | Software-interrupt request; not maskable |
| i_mask | input | 1 | Interrupt mask bit; 1 blocks hardware requests |
| start_strb | input | 1 | Start of interrupt processing; triggers arbitration |
| svc_ack | input | 1 | Latched interrupt has been serviced |
| irq_pend | output | 1 | An unmasked or software request is present |
| vec_valid | output | 1 | A selection is held |
| vec_code | output | CODE_W | Held vector code: 0 none, 1 software, i+2 hardware line i |

## Verification
A new arbitration strobe and a release (an acknowledge or a falling mask bit) can land in the same cycle. The bench forces this in two cases: with a selection held, and with nothing held. In the first case it expects the release to win. In the second it expects a fresh latch. Random traffic also produces strobes, acknowledges and mask toggles together at their own rates. Every cycle is compared with a bench model that keeps the held state and the previous mask value.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    // Vector code assignment
    localparam int CODE_NONE    = 0;
    localparam int CODE_SWI     = 1;
    localparam int CODE_HW_BASE = 2;

    // Width needed to encode none, software and every hardware line
    function automatic int code_width(input int n_src);
        return $clog2(n_src + CODE_HW_BASE);
    endfunction

    typedef enum logic {
        SEL_IDLE = 1'b0,
        SEL_HELD = 1'b1
    } sel_state_e;

endpackage

// File: rtl/irq_req_qualifier.sv
module irq_req_qualifier
#(
    parameter int NUM_SRC = 8
)
(
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic               swi_req,
    input  logic               i_mask,
    output logic [NUM_SRC-1:0] hw_live,
    output logic               pend
);

    // Hardware lines pass only while the mask is clear
    always_comb begin
        hw_live = irq_req & {NUM_SRC{~i_mask}};
        pend    = swi_req | (|hw_live);
    end

endmodule

// File: rtl/irq_prio_encoder.sv
module irq_prio_encoder
    import irq_arb_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int CODE_W  = code_width(NUM_SRC)
)
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_SRC-1:0] hw_live,
    input  logic              swi_req,
    output logic [CODE_W-1:0] win_code
);

    logic [NUM_SRC:0]   taken;
    logic [NUM_SRC-1:0] grant;

    assign taken[0] = 1'b0;

    // Fixed priority chain: a line is granted only if no lower index requests
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_chain
        assign grant[g]     = hw_live[g] & ~taken[g];
        assign taken[g + 1] = taken[g] | hw_live[g];
    end

    always_comb begin
        win_code = CODE_W'(CODE_NONE);
        for (int i = 0; i < NUM_SRC; i++) begin
            if (grant[i]) win_code = CODE_W'(CODE_HW_BASE + i);
        end
        if (swi_req) win_code = CODE_W'(CODE_SWI);
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant)); // R4
    AST_LOW_INDEX_WINS: assert property (@(posedge clk) disable iff (rst)
        (hw_live[0] && !swi_req) |-> win_code == CODE_W'(CODE_HW_BASE)); // R4

endmodule

// File: rtl/irq_mask_edge.sv
module irq_mask_edge
(
    input  logic clk,
    input  logic rst,
    input  logic i_mask,
    output logic mask_fall
);

    logic mask_q;

    // Previous mask value; reset treats the mask as set
    always_ff @(posedge clk) begin
        if (rst) mask_q <= 1'b1;
        else     mask_q <= i_mask;
    end

    assign mask_fall = mask_q & ~i_mask;

    AST_FALL_AFTER_SET: assert property (@(posedge clk) disable iff (rst)
        mask_fall |-> $past(i_mask)); // R8

endmodule

// File: rtl/irq_select_latch.sv
module irq_select_latch
    import irq_arb_pkg::*;
#(
    parameter int CODE_W = 4
)
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_strb,
    input  logic              pend,
    input  logic [CODE_W-1:0] win_code,
    input  logic              svc_ack,
    input  logic              mask_fall,
    output logic              held,
    output logic [CODE_W-1:0] held_code
);

    typedef struct packed {
        sel_state_e        st;
        logic [CODE_W-1:0] code;
    } sel_t;

    sel_t cur, nxt;
    logic release_now;

    assign release_now = svc_ack | mask_fall;

    always_comb begin
        nxt = cur;
        if (cur.st == SEL_HELD) begin
            if (release_now) begin
                nxt.st   = SEL_IDLE;
                nxt.code = CODE_W'(CODE_NONE);
            end
        end else if (start_strb && pend) begin
            nxt.st   = SEL_HELD;
            nxt.code = win_code;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.st   <= SEL_IDLE;
            cur.code <= CODE_W'(CODE_NONE);
        end else begin
            cur <= nxt;
        end
    end

    assign held      = (cur.st == SEL_HELD);
    assign held_code = cur.code;

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (held && !svc_ack && !mask_fall) |=> (held && $stable(held_code))); // R6
    AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (rst)
        (held && svc_ack) |=> (!held && held_code == '0)); // R7
    AST_FALL_RELEASES: assert property (@(posedge clk) disable iff (rst)
        (held && mask_fall) |=> !held); // R8
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !held |-> held_code == '0); // R5
    AST_NO_PEND_NO_LATCH: assert property (@(posedge clk) disable iff (rst)
        (!held && !pend) |=> !held); // R5

endmodule

// File: rtl/irq_latch_arbiter.sv
module irq_latch_arbiter
    import irq_arb_pkg::*;
#(
    parameter int NUM_SRC = 8,
    localparam int CODE_W = code_width(NUM_SRC)
)
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic               swi_req,
    input  logic               i_mask,
    input  logic               start_strb,
    input  logic               svc_ack,
    output logic               irq_pend,
    output logic               vec_valid,
    output logic [CODE_W-1:0]  vec_code
);

    logic [NUM_SRC-1:0] hw_live;
    logic [CODE_W-1:0]  win_code;
    logic               mask_fall;

    irq_req_qualifier #(.NUM_SRC(NUM_SRC)) u_qual (
        .irq_req (irq_req),
        .swi_req (swi_req),
        .i_mask  (i_mask),
        .hw_live (hw_live),
        .pend    (irq_pend)
    );

    irq_prio_encoder #(.NUM_SRC(NUM_SRC), .CODE_W(CODE_W)) u_prio (
        .clk      (clk),
        .rst      (rst),
        .hw_live  (hw_live),
        .swi_req  (swi_req),
        .win_code (win_code)
    );

    irq_mask_edge u_edge (
        .clk       (clk),
        .rst       (rst),
        .i_mask    (i_mask),
        .mask_fall (mask_fall)
    );

    irq_select_latch #(.CODE_W(CODE_W)) u_latch (
        .clk        (clk),
        .rst        (rst),
        .start_strb (start_strb),
        .pend       (irq_pend),
        .win_code   (win_code),
        .svc_ack    (svc_ack),
        .mask_fall  (mask_fall),
        .held       (vec_valid),
        .held_code  (vec_code)
    );

    AST_MASK_BLOCKS_HW: assert property (@(posedge clk) disable iff (rst)
        (i_mask && !swi_req) |-> !irq_pend); // R2
    AST_SWI_WINS: assert property (@(posedge clk) disable iff (rst)
        (!vec_valid && start_strb && swi_req) |=> vec_code == CODE_W'(CODE_SWI)); // R3
    AST_STROBE_WHILE_HELD: assert property (@(posedge clk) disable iff (rst)
        (vec_valid && start_strb && svc_ack) |=> !vec_valid); // R9

endmodule

// File: tb/tb_irq_latch_arbiter.sv
`timescale 1ns/1ps
module tb_irq_latch_arbiter;

    localparam int NUM_SRC = 8;
    localparam int CODE_W  = $clog2(NUM_SRC + 2);

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [NUM_SRC-1:0] irq_req = '0;
    logic               swi_req = 1'b0;
    logic               i_mask = 1'b1;
    logic               start_strb = 1'b0;
    logic               svc_ack = 1'b0;
    logic               irq_pend;
    logic               vec_valid;
    logic [CODE_W-1:0]  vec_code;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench model state
    bit          m_valid;
    int unsigned m_code;
    bit          m_maskq;

    always #2.5 clk = ~clk;

    irq_latch_arbiter #(.NUM_SRC(NUM_SRC)) dut (
        .clk(clk), .rst(rst), .irq_req(irq_req), .swi_req(swi_req),
        .i_mask(i_mask), .start_strb(start_strb), .svc_ack(svc_ack),
        .irq_pend(irq_pend), .vec_valid(vec_valid), .vec_code(vec_code)
    );

    function automatic bit exp_pend(input logic [NUM_SRC-1:0] r, input bit s, input bit m);
        return s || ((r != '0) && !m);
    endfunction

    function automatic int unsigned exp_winner(input logic [NUM_SRC-1:0] r, input bit s, input bit m);
        if (s) return 1;
        if (m) return 0;
        for (int i = 0; i < NUM_SRC; i++) if (r[i]) return i + 2;
        return 0;
    endfunction

    task automatic check(input string tag, input int unsigned act, input int unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input logic [NUM_SRC-1:0] r, input bit s, input bit m,
                        input bit st, input bit ak, input string tag);
        bit p;
        bit fall;
        @(negedge clk);
        irq_req = r; swi_req = s; i_mask = m; start_strb = st; svc_ack = ak;
        #1;
        p = exp_pend(r, s, m);
        check("R2 pend", irq_pend, p);
        fall = m_maskq && !m;
        if (m_valid) begin
            if (ak || fall) begin m_valid = 0; m_code = 0; end
        end else if (st && p) begin
            m_valid = 1; m_code = exp_winner(r, s, m);
        end
        m_maskq = m;
        @(posedge clk);
        #1;
        check({tag, " valid"}, vec_valid, m_valid);
        check({tag, " code"}, vec_code, m_code);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        m_valid = 0; m_code = 0; m_maskq = 1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        check("R1 valid", vec_valid, 0);
        check("R1 code", vec_code, 0);

        // Directed corner cases
        step(8'b0010_0000, 0, 0, 1, 0, "R3 latch hw");
        check("R4 line5 code", vec_code, 7);
        step(8'b0000_0001, 1, 0, 1, 0, "R6 no preempt");
        check("R6 held code", vec_code, 7);
        step(8'b0000_0000, 0, 0, 0, 1, "R7 ack");
        step(8'b0000_1010, 0, 0, 1, 0, "R4 lowest index");
        check("R4 line1 code", vec_code, 3);
        step(8'b1111_1111, 0, 0, 1, 1, "R9 release beats strobe");
        step(8'b0000_0100, 0, 0, 1, 1, "R9 ack idle then latch");
        check("R9 latched code", vec_code, 4);
        step(8'b0000_0000, 0, 0, 0, 1, "R7 ack again");
        step(8'b1111_1111, 0, 1, 1, 0, "R5 masked strobe");
        step(8'b0000_0000, 0, 1, 1, 0, "R5 empty strobe");
        step(8'b1111_1111, 1, 1, 1, 0, "R3 swi masked");
        check("R3 swi code", vec_code, 1);
        step(8'b0000_0000, 0, 1, 0, 0, "R6 hold masked");
        step(8'b0000_0000, 0, 0, 0, 0, "R8 mask fall");
        check("R8 released", vec_valid, 0);

        // Random traffic
        for (int n = 0; n < 4000; n++) begin
            logic [NUM_SRC-1:0] r;
            bit m;
            r = NUM_SRC'($urandom) & NUM_SRC'($urandom);
            m = ($urandom_range(7) == 0) ? !i_mask : i_mask;
            step(r, $urandom_range(9) == 0, m, $urandom_range(3) == 0,
                 $urandom_range(5) == 0, "R6 random");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule